// File: doc/BRIEF.md
# Redundant-Thread Load Hold Table

This block sits beside a data cache shared by two copies of one program: a leading thread and a trailing thread that re-executes the same loads later. Both threads must read identical data, so a cache line that the leading thread has read must stay in place until the trailing thread has read it too. The table keeps one entry per such line. Each entry holds the line address, a count of trailing-thread loads still owed to that line, and a flag recording that an invalidation was refused.

Each cycle the leading thread may present one load, the trailing thread may present one load, and the cache may ask whether one line can be replaced or invalidated. The answer to that question and the stall signal for the leading thread are combinational, so they are valid in the same cycle as the request. When a line whose invalidation was refused loses its last outstanding load, the table issues a one-cycle deferred-invalidate notice carrying that line address. A stall that lasts a programmable number of cycles with no trailing-thread progress raises a deadlock flag. Recovery from a deadlock is left to the surrounding logic.

Top module: `lhb_table`

## Requirements
- R1: A leading load (`lead_vld`) to an address with no entry, while an entry is free, creates an entry for that address with a count of 1. From the next cycle on, replacement queries for that address are denied.
- R2: A leading load to an address that has an entry, and whose count is below its maximum, raises that count by one. A line loaded N times needs N trailing loads before it is released.
- R3: A trailing load (`trail_vld`) to an address with an entry lowers its count by one. When the count reaches zero the entry is released, and from the next cycle on queries for that address are allowed and the entry counts as free.
- R4: A leading and a trailing load to the same tracked address in the same cycle leave its count unchanged.
- R5: `evq_allow` is 0 in the same cycle when `evq_vld` is 1 and `evq_addr` has an entry. Otherwise it is 1, including whenever `evq_vld` is 0.
- R6: A denied query with `evq_inval` = 1 (invalidate) marks the entry pending. A denied query with `evq_inval` = 0 (replace) does not. When a pending entry is released, or when an entry is released in the same cycle that an invalidate query to it is denied, `dinv_vld` is 1 for exactly the next cycle and `dinv_addr` holds that address.
- R7: `table_full` is 1 when every entry is in use. `lead_stall` is 1 in the same cycle when `lead_vld` is 1, the address has no entry and no entry is free. A stalled load changes nothing.
- R8: A leading load to a tracked address whose count equals 2^CNT_W-1 stalls and leaves the count unchanged.
- R9: `deadlock` is 1 once `lead_stall` has been 1 for `tmo_limit` consecutive cycles, none of which had a trailing load to a tracked address. It returns to 0 in the cycle after a cycle that breaks that condition. With `tmo_limit` = 0 it stays 0.
- R10: After reset the table is empty: `table_full`, `lead_stall`, `dinv_vld` and `deadlock` are 0 and every query is allowed.
- R11: A trailing load to an address with no entry changes no entry and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_vld | input | 1 | Leading-thread load present |
| lead_addr | input | ADDR_W | Line address of the leading load |
| trail_vld | input | 1 | Trailing-thread load present |
| trail_addr | input | ADDR_W | Line address of the trailing load |
| evq_vld | input | 1 | Replace/invalidate query present |
| evq_inval | input | 1 | 1 = invalidate query, 0 = replacement query |
| evq_addr | input | ADDR_W | Line address being queried |
| tmo_limit | input | TMO_W | Stall cycles before deadlock is flagged; 0 disables the flag |
| evq_allow | output | 1 | 1 = the queried line may be evicted or invalidated |
| lead_stall | output | 1 | Leading load cannot be accepted this cycle |
| table_full | output | 1 | Every entry is in use |
| dinv_vld | output | 1 | Deferred-invalidate notice |
| dinv_addr | output | ADDR_W | Address of the deferred invalidation |
| deadlock | output | 1 | Stall has lasted past the limit with no trailing progress |

## Verification
The hardest cases to reach are the rare coincidences. One is an invalidate query that is denied in the same cycle the trailing thread releases the line. Another is a count driven to saturation. A third is a stall held long enough for the deadlock limit. Random traffic over a wide address space almost never produces these. The stimulus therefore uses directed sequences that fill every entry, or load one line repeatedly, and then hold the leading thread stalled while the trailing thread stays idle. These sequences are followed by random traffic over six addresses, so that a four-entry table is full and contended most of the time. A behavioural model built on an associative array predicts every output on every cycle.

// File: rtl/lhb_pkg.sv
package lhb_pkg;

  typedef enum logic {
    Q_REPLACE = 1'b0,
    Q_INVAL   = 1'b1
  } qkind_e;

  // Outstanding-load count after one cycle of leading and trailing traffic.
  function automatic int unsigned count_step(int unsigned c, logic up, logic dn);
    int unsigned r;
    r = c;
    if (up) r = r + 1;
    if (dn) r = r - 1;
    return r;
  endfunction

  // Consecutive stalled-without-progress cycles, saturating at smax.
  function automatic int unsigned streak_step(int unsigned s, int unsigned smax, logic grow);
    if (!grow) return 0;
    if (s >= smax) return smax;
    return s + 1;
  endfunction

endpackage

// File: rtl/lhb_slot.sv
module lhb_slot #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              inc,
  input  logic              dec,
  input  logic              mark,
  input  logic [ADDR_W-1:0] tag_in,
  output logic              busy,
  output logic [ADDR_W-1:0] tag,
  output logic [CNT_W-1:0]  cnt,
  output logic              pend,
  output logic              rel_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    rel_o = busy && dec && !inc && (cnt == ONE);
    cnt_d = CNT_W'(lhb_pkg::count_step(32'(cnt), inc, dec));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tag  <= '0;
      cnt  <= '0;
      pend <= 1'b0;
    end else if (alloc) begin
      busy <= 1'b1;
      tag  <= tag_in;
      cnt  <= ONE;
      pend <= 1'b0;
    end else if (rel_o) begin
      busy <= 1'b0;
      cnt  <= '0;
      pend <= 1'b0;
    end else if (busy) begin
      cnt <= cnt_d;
      if (mark) pend <= 1'b1;
    end
  end

endmodule

// File: rtl/lhb_match.sv
module lhb_match #(
  parameter int N      = 16,
  parameter int ADDR_W = 32
) (
  input  logic                     en,
  input  logic [ADDR_W-1:0]        key,
  input  logic [N-1:0]             busy,
  input  logic [N-1:0][ADDR_W-1:0] tags,
  output logic [N-1:0]             hit_vec,
  output logic                     hit
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = en && busy[i] && (tags[i] == key);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/lhb_pick.sv
module lhb_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] busy,
  output logic [N-1:0] free_oh,
  output logic         any_free
);

  logic [N-1:0] free_vec;

  always_comb begin
    free_vec = ~busy;
    free_oh  = free_vec & (~free_vec + N'(1));
    any_free = |free_vec;
  end

endmodule

// File: rtl/lhb_stallwatch.sv
module lhb_stallwatch #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             progress,
  input  logic [TMO_W-1:0] limit,
  output logic             deadlock
);

  localparam int unsigned SMAX = (1 << TMO_W) - 1;

  logic [TMO_W-1:0] streak_q;
  logic             grow;

  assign grow = stall && !progress;

  always_ff @(posedge clk) begin
    if (!rst_n) streak_q <= '0;
    else        streak_q <= TMO_W'(lhb_pkg::streak_step(32'(streak_q), SMAX, grow));
  end

  assign deadlock = (limit != '0) && (streak_q >= limit);

endmodule

// File: rtl/lhb_table.sv
module lhb_table #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 6,
  parameter int TMO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_vld,
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic              trail_vld,
  input  logic [ADDR_W-1:0] trail_addr,
  input  logic              evq_vld,
  input  logic              evq_inval,
  input  logic [ADDR_W-1:0] evq_addr,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              evq_allow,
  output logic              lead_stall,
  output logic              table_full,
  output logic              dinv_vld,
  output logic [ADDR_W-1:0] dinv_addr,
  output logic              deadlock
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ENTRIES-1:0]             busy_vec, pend_vec, rel_vec;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_arr;
  logic [ENTRIES-1:0][CNT_W-1:0]  cnt_arr;

  logic [ENTRIES-1:0] lead_hit_vec, trail_hit_vec, ev_hit_vec;
  logic               lead_hit, trail_hit, ev_hit;
  logic [ENTRIES-1:0] free_oh;
  logic               any_free;

  logic [ENTRIES-1:0] inc_vec, dec_vec, alloc_vec, mark_vec, defer_vec;
  logic [CNT_W-1:0]   lead_cnt;
  logic               lead_sat, lead_take;
  logic [ADDR_W-1:0]  defer_addr;
  lhb_pkg::qkind_e    qkind;

  lhb_match #(.N(ENTRIES), .ADDR_W(ADDR_W)) u_lead_match (
    .en(lead_vld), .key(lead_addr), .busy(busy_vec), .tags(tag_arr),
    .hit_vec(lead_hit_vec), .hit(lead_hit));

  lhb_match #(.N(ENTRIES), .ADDR_W(ADDR_W)) u_trail_match (
    .en(trail_vld), .key(trail_addr), .busy(busy_vec), .tags(tag_arr),
    .hit_vec(trail_hit_vec), .hit(trail_hit));

  lhb_match #(.N(ENTRIES), .ADDR_W(ADDR_W)) u_evq_match (
    .en(evq_vld), .key(evq_addr), .busy(busy_vec), .tags(tag_arr),
    .hit_vec(ev_hit_vec), .hit(ev_hit));

  lhb_pick #(.N(ENTRIES)) u_pick (
    .busy(busy_vec), .free_oh(free_oh), .any_free(any_free));

  // count of the entry the leading load hits (at most one hits)
  always_comb begin
    lead_cnt = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lead_hit_vec[i]) lead_cnt = lead_cnt | cnt_arr[i];
  end

  assign qkind      = lhb_pkg::qkind_e'(evq_inval);
  assign lead_sat   = lead_hit && (lead_cnt == CNT_MAX);
  assign lead_stall = lead_vld && (lead_hit ? lead_sat : !any_free);
  assign lead_take  = lead_vld && !lead_stall;

  assign inc_vec   = lead_hit_vec & {ENTRIES{lead_take}};
  assign alloc_vec = free_oh & {ENTRIES{lead_take && !lead_hit}};
  assign dec_vec   = trail_hit_vec;
  assign mark_vec  = ev_hit_vec & {ENTRIES{qkind == lhb_pkg::Q_INVAL}};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    lhb_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_vec[i]), .inc(inc_vec[i]), .dec(dec_vec[i]), .mark(mark_vec[i]),
      .tag_in(lead_addr),
      .busy(busy_vec[i]), .tag(tag_arr[i]), .cnt(cnt_arr[i]),
      .pend(pend_vec[i]), .rel_o(rel_vec[i]));
  end

  assign defer_vec = rel_vec & (pend_vec | mark_vec);

  always_comb begin
    defer_addr = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (defer_vec[i]) defer_addr = defer_addr | tag_arr[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dinv_vld  <= 1'b0;
      dinv_addr <= '0;
    end else begin
      dinv_vld <= |defer_vec;
      if (|defer_vec) dinv_addr <= defer_addr;
    end
  end

  assign evq_allow  = !ev_hit;
  assign table_full = &busy_vec;

  lhb_stallwatch #(.TMO_W(TMO_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .stall(lead_stall), .progress(trail_hit),
    .limit(tmo_limit), .deadlock(deadlock));

endmodule

// File: rtl/lhb_checker.sv
module lhb_checker #(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 6,
  parameter int TMO_W   = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          trail_vld,
  input logic                          evq_vld,
  input logic                          evq_allow,
  input logic                          lead_stall,
  input logic                          table_full,
  input logic                          dinv_vld,
  input logic                          deadlock,
  input logic [TMO_W-1:0]              tmo_limit,
  input logic                          lead_hit,
  input logic                          trail_hit,
  input logic [ENTRIES-1:0]            inc_vec,
  input logic [ENTRIES-1:0]            dec_vec,
  input logic [ENTRIES-1:0]            rel_vec,
  input logic [ENTRIES-1:0][CNT_W-1:0] cnt_arr
);

  // R7
  stall_miss_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stall && !lead_hit) |-> table_full);

  // R5
  idle_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evq_vld |-> evq_allow);

  // R6
  dinv_after_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dinv_vld |-> $past(trail_vld && trail_hit));

  // R9
  deadlock_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |-> (tmo_limit != '0));

  // R9
  deadlock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadlock) |-> $past(lead_stall && !trail_hit));

  // R3
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_vec) |=> !table_full);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    // R4
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_vec[i] && dec_vec[i]) |=> $stable(cnt_arr[i]));
    // R2
    bump_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_vec[i] && !dec_vec[i]) |=> (cnt_arr[i] == $past(cnt_arr[i]) + CNT_W'(1)));
  end

endmodule

bind lhb_table lhb_checker #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trail_vld(trail_vld), .evq_vld(evq_vld),
  .evq_allow(evq_allow), .lead_stall(lead_stall), .table_full(table_full),
  .dinv_vld(dinv_vld), .deadlock(deadlock), .tmo_limit(tmo_limit),
  .lead_hit(lead_hit), .trail_hit(trail_hit), .inc_vec(inc_vec),
  .dec_vec(dec_vec), .rel_vec(rel_vec), .cnt_arr(cnt_arr));

// File: tb/lhb_table_tb.sv
`timescale 1ns/1ps
module lhb_table_tb;

  localparam int NE   = 4;
  localparam int AW   = 16;
  localparam int CW   = 3;
  localparam int TW   = 8;
  localparam int CMAX = (1 << CW) - 1;
  localparam int SMAX = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lead_vld = 1'b0, trail_vld = 1'b0, evq_vld = 1'b0, evq_inval = 1'b0;
  logic [AW-1:0] lead_addr = '0, trail_addr = '0, evq_addr = '0;
  logic [TW-1:0] tmo_limit = TW'(5);
  logic          evq_allow, lead_stall, table_full, dinv_vld, deadlock;
  logic [AW-1:0] dinv_addr;

  always #2.5 clk = ~clk;

  lhb_table #(.ENTRIES(NE), .ADDR_W(AW), .CNT_W(CW), .TMO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lead_vld(lead_vld), .lead_addr(lead_addr),
    .trail_vld(trail_vld), .trail_addr(trail_addr),
    .evq_vld(evq_vld), .evq_inval(evq_inval), .evq_addr(evq_addr),
    .tmo_limit(tmo_limit), .evq_allow(evq_allow), .lead_stall(lead_stall),
    .table_full(table_full), .dinv_vld(dinv_vld), .dinv_addr(dinv_addr),
    .deadlock(deadlock));

  // behavioural reference: outstanding count and pending flag per address
  int unsigned m_cnt[int unsigned];
  bit          m_pend[int unsigned];
  bit          exp_dv;
  int unsigned exp_da;
  int unsigned streak;

  int    n_chk = 0, n_fail = 0;
  bit    finished = 1'b0;
  string cur = "R10";

  task automatic chk(string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lead_vld = 1'b0; trail_vld = 1'b0; evq_vld = 1'b0; evq_inval = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_cnt.delete(); m_pend.delete();
    exp_dv = 1'b0; exp_da = 0; streak = 0;
  endtask

  task automatic step(input bit lv, input int unsigned la, input bit tv, input int unsigned ta,
                      input bit ev, input bit ei, input int unsigned ea);
    bit lhit, sat, xstall, thit, inc, alloc, same, setp, nx_dv;
    int unsigned nx_da;
    @(negedge clk);
    lead_vld = lv;  lead_addr = AW'(la);
    trail_vld = tv; trail_addr = AW'(ta);
    evq_vld = ev;   evq_inval = ei; evq_addr = AW'(ea);
    #1;
    lhit   = m_cnt.exists(la);
    sat    = lhit && (m_cnt[la] == CMAX);
    xstall = lv && (lhit ? sat : (m_cnt.num() == NE));
    thit   = tv && m_cnt.exists(ta);
    chk("lead_stall", lead_stall, xstall);
    chk("table_full", table_full, m_cnt.num() == NE);
    chk("evq_allow", evq_allow, !(ev && m_cnt.exists(ea)));
    chk("dinv_vld", dinv_vld, exp_dv);
    if (exp_dv) chk("dinv_addr", dinv_addr, exp_da);
    chk("deadlock", deadlock, (tmo_limit != 0) && (streak >= tmo_limit));
    // next state
    inc   = lv && !xstall && lhit;
    alloc = lv && !xstall && !lhit;
    setp  = ev && ei && m_cnt.exists(ea);
    same  = inc && thit && (la == ta);
    nx_dv = 1'b0; nx_da = 0;
    if (thit && !same) begin
      m_cnt[ta] = m_cnt[ta] - 1;
      if (m_cnt[ta] == 0) begin
        if (m_pend[ta] || (setp && ea == ta)) begin nx_dv = 1'b1; nx_da = ta; end
        m_cnt.delete(ta); m_pend.delete(ta);
      end
    end
    if (inc && !same) m_cnt[la] = m_cnt[la] + 1;
    if (alloc) begin m_cnt[la] = 1; m_pend[la] = 1'b0; end
    if (setp && m_cnt.exists(ea)) m_pend[ea] = 1'b1;
    if (xstall && !thit) streak = (streak >= SMAX) ? SMAX : streak + 1;
    else                 streak = 0;
    exp_dv = nx_dv; exp_da = nx_da;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic lead(int unsigned a); step(1, a, 0, 0, 0, 0, 0); endtask
  task automatic trail(int unsigned a); step(0, 0, 1, a, 0, 0, 0); endtask
  task automatic query(int unsigned a, bit inv); step(0, 0, 0, 0, 1, inv, a); endtask

  initial begin
    do_reset();
    cur = "R10"; idle(); query(77, 0);
    cur = "R1";  lead(100); query(100, 0);
    cur = "R2";  lead(100); lead(100); trail(100); trail(100); query(100, 0);
    cur = "R3";  trail(100); query(100, 0); idle();
    cur = "R4";  lead(200); step(1, 200, 1, 200, 0, 0, 0); query(200, 0);
                 trail(200); query(200, 1);
    cur = "R11"; lead(250); trail(300); query(300, 0); query(250, 0); trail(250); idle();
    cur = "R6";  lead(400); query(400, 1); trail(400); idle(); idle();
                 lead(401); query(401, 0); trail(401); idle();
                 lead(402); step(0, 0, 1, 402, 1, 1, 402); idle(); idle();
    cur = "R8";  do_reset();
                 for (int k = 0; k < CMAX; k++) lead(500);
                 lead(500); query(500, 0); trail(500); lead(500); lead(500);
    cur = "R7";  do_reset();
                 for (int k = 1; k <= NE; k++) lead(k);
                 lead(9); lead(9); query(9, 0);
    cur = "R9";  tmo_limit = TW'(5);
                 for (int k = 0; k < 8; k++) lead(9);
                 step(1, 9, 1, 1, 0, 0, 0); lead(9); idle(); idle();
                 tmo_limit = TW'(0);
                 for (int k = 0; k < 8; k++) lead(9);
                 idle();
    cur = "R5";  do_reset(); tmo_limit = TW'(3);
    for (int k = 0; k < 600; k++) begin
      step($urandom_range(0, 1), $urandom_range(1, 6), $urandom_range(0, 1), $urandom_range(1, 6),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(1, 6));
    end
    idle();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL %s watchdog: actual %0d expected %0d", cur, 0, 1);
      summary();
      $finish;
    end
  end

endmodule